// File: doc/BRIEF.md
# GPIO Port with Masked Output Writes

This block is a 32-pin general-purpose I/O port attached to a plain 32-bit register bus made of an address, a write strobe, write data and read data. It produces a pad output value vector and a pad output-enable vector, and it receives the pad input levels. Every pin starts as an input. Software changes a pin's direction by writing a one to that pin's bit in one of two set-only registers. One register turns pins into outputs and the other turns them into inputs. Zero bits in either register leave their pins as they were.

Output values live in two 16-pin latches, one for the low pins and one for the high pins. Each latch is written through a word whose upper half-word is a per-bit enable for the lower half-word. A single pin can therefore change in one bus write, with no read-modify-write. The latch keeps its value while its pin is an input, so a level can be loaded before the driver is switched on. Pad inputs pass through a two-stage synchronizer before software can read them.

Top module: `gpio_port_masked`

## Requirements
- R1: After reset every pin is an input (pad_oe all 0) and both output latches hold 0 (pad_out all 0). A read of offset 0x04, 0x08 or 0x0C returns 0.
- R2: A write to offset 0x00 sets the direction bit of every pin whose data bit is 1 (1 = output, driven on pad_oe). Pins whose data bit is 0 keep their direction.
- R3: A write to offset 0x04 clears the direction bit of every pin whose data bit is 1. Pins whose data bit is 0 keep their direction.
- R4: A read of offset 0x04 returns the direction vector, bit n for pin n, with 1 meaning output.
- R5: A write to offset 0x08 (pins 0..15) or 0x0C (pins 16..31) copies data bit k (k in 0..15) into that half's latch only where data bit k+16 is 1. All other latch bits keep their value. The latches drive pad_out.
- R6: A read of offset 0x08 or 0x0C returns that half's latch in bits 15:0 and zero in bits 31:16.
- R7: An output latch bit keeps its value across changes of its pin's direction. A value loaded while the pin is an input appears as the pin's pad_out level once the pin is made an output.
- R8: A read of offset 0x10 returns pad_in delayed by exactly two clock edges. A level applied before edge k is visible after edge k+1 and not after edge k.
- R9: Writes to any offset other than 0x00, 0x04, 0x08 and 0x0C, including 0x10, change neither the direction nor the latches. Reads of unmapped offsets, including 0x00, return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the register |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pad_in | input | 32 | Asynchronous pad input levels |
| pad_out | output | 32 | Output latch values |
| pad_oe | output | 32 | Output enables (direction vector) |

## Verification
A wrong direction bit shows on pad_oe one edge after the write that caused it. A wrong latch bit shows on pad_out on the same edge, and both can also be read back through the bus in the next cycle. A mask decode error shows up when a single-bit write disturbs a neighbouring pin, so the patterns used mix set and clear masks with nonzero data in the unmasked bits. A synchronizer with the wrong depth shows only in timing, so the input read is sampled both one and two edges after the pads change.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  localparam int WORD_W = 32;
  localparam int HALF_W = WORD_W / 2;

  localparam logic [7:0] OFS_MAKE_OUT = 8'h00;
  localparam logic [7:0] OFS_MAKE_IN  = 8'h04;
  localparam logic [7:0] OFS_LAT_LO   = 8'h08;
  localparam logic [7:0] OFS_LAT_HI   = 8'h0C;
  localparam logic [7:0] OFS_PINS     = 8'h10;

  typedef enum logic [2:0] {
    RSEL_NONE,
    RSEL_DIR,
    RSEL_LAT_LO,
    RSEL_LAT_HI,
    RSEL_PINS
  } rsel_e;

  // Merge value bits into a half latch under the upper-half enable mask.
  function automatic logic [HALF_W-1:0] merge_masked(
    input logic [HALF_W-1:0] cur,
    input logic [WORD_W-1:0] word
  );
    logic [HALF_W-1:0] en;
    en = word[WORD_W-1:HALF_W];
    return (cur & ~en) | (word[HALF_W-1:0] & en);
  endfunction

  // Next direction vector from the set and clear requests.
  function automatic logic [WORD_W-1:0] dir_next(
    input logic [WORD_W-1:0] cur,
    input logic [WORD_W-1:0] to_out,
    input logic [WORD_W-1:0] to_in
  );
    return (cur | to_out) & ~to_in;
  endfunction

endpackage

// File: rtl/gpio_bus_decode.sv
module gpio_bus_decode
  import gpio_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output logic              wr_make_out,
  output logic              wr_make_in,
  output logic              wr_lat_lo,
  output logic              wr_lat_hi,
  output rsel_e             rsel
);

  logic hit_out, hit_in, hit_lo, hit_hi, hit_pins;

  assign hit_out  = (addr == ADDR_W'(OFS_MAKE_OUT));
  assign hit_in   = (addr == ADDR_W'(OFS_MAKE_IN));
  assign hit_lo   = (addr == ADDR_W'(OFS_LAT_LO));
  assign hit_hi   = (addr == ADDR_W'(OFS_LAT_HI));
  assign hit_pins = (addr == ADDR_W'(OFS_PINS));

  assign wr_make_out = we && hit_out;
  assign wr_make_in  = we && hit_in;
  assign wr_lat_lo   = we && hit_lo;
  assign wr_lat_hi   = we && hit_hi;

  always_comb begin
    rsel = RSEL_NONE;
    if (hit_in)        rsel = RSEL_DIR;
    else if (hit_lo)   rsel = RSEL_LAT_LO;
    else if (hit_hi)   rsel = RSEL_LAT_HI;
    else if (hit_pins) rsel = RSEL_PINS;
  end

endmodule

// File: rtl/gpio_dir_reg.sv
module gpio_dir_reg
  import gpio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic              clr_en,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] dir
);

  logic [WORD_W-1:0] to_out, to_in;

  assign to_out = set_en ? wdata : '0;
  assign to_in  = clr_en ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dir <= '0;
    else        dir <= dir_next(dir, to_out, to_in);
  end

  AST_DIR_SET_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> ((dir & $past(wdata)) == $past(wdata))); // R2

  AST_DIR_CLR_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> ((dir & $past(wdata)) == '0)); // R3

  AST_DIR_ZERO_BITS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en || clr_en) |=> (((dir ^ $past(dir)) & ~$past(wdata)) == '0)); // R2

  AST_DIR_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_en || clr_en) |=> $stable(dir)); // R9

endmodule

// File: rtl/gpio_out_half.sv
module gpio_out_half
  import gpio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wdata,
  output logic [HALF_W-1:0] lat
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lat <= '0;
    else if (wr_en) lat <= merge_masked(lat, wdata);
  end

  AST_LAT_UNMASKED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (((lat ^ $past(lat)) & ~$past(wdata[WORD_W-1:HALF_W])) == '0)); // R5

  AST_LAT_MASKED_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((lat & $past(wdata[WORD_W-1:HALF_W])) ==
               ($past(wdata[HALF_W-1:0]) & $past(wdata[WORD_W-1:HALF_W])))); // R5

  AST_LAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(lat)); // R7

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] d_sync
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= d_async;
      end
      AST_SYNC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (stage_q[0] == $past(d_async))); // R8
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
      AST_SYNC_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (stage_q[s] == $past(stage_q[s-1]))); // R8
    end
  end

  assign d_sync = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_port_masked.sv
module gpio_port_masked
  import gpio_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [31:0]       pad_in,
  output logic [31:0]       pad_out,
  output logic [31:0]       pad_oe
);

  localparam int N_HALVES = WORD_W / HALF_W;

  logic              wr_make_out, wr_make_in, wr_lat_lo, wr_lat_hi;
  rsel_e             rsel;
  logic [WORD_W-1:0] dir_q;
  logic [WORD_W-1:0] pins_sync;
  logic [HALF_W-1:0] lat_q [N_HALVES];
  logic              lat_wr [N_HALVES];

  gpio_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr        (bus_addr),
    .we          (bus_we),
    .wr_make_out (wr_make_out),
    .wr_make_in  (wr_make_in),
    .wr_lat_lo   (wr_lat_lo),
    .wr_lat_hi   (wr_lat_hi),
    .rsel        (rsel)
  );

  gpio_dir_reg u_dir (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_en (wr_make_out),
    .clr_en (wr_make_in),
    .wdata  (bus_wdata),
    .dir    (dir_q)
  );

  assign lat_wr[0] = wr_lat_lo;
  assign lat_wr[1] = wr_lat_hi;

  for (genvar h = 0; h < N_HALVES; h++) begin : g_half
    gpio_out_half u_half (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (lat_wr[h]),
      .wdata (bus_wdata),
      .lat   (lat_q[h])
    );
    assign pad_out[h*HALF_W +: HALF_W] = lat_q[h];
  end

  gpio_in_sync #(.WIDTH(WORD_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (pad_in),
    .d_sync  (pins_sync)
  );

  assign pad_oe = dir_q;

  always_comb begin
    unique case (rsel)
      RSEL_DIR:    bus_rdata = dir_q;
      RSEL_LAT_LO: bus_rdata = {{HALF_W{1'b0}}, lat_q[0]};
      RSEL_LAT_HI: bus_rdata = {{HALF_W{1'b0}}, lat_q[1]};
      RSEL_PINS:   bus_rdata = pins_sync;
      default:     bus_rdata = '0;
    endcase
  end

  AST_ONE_WRITE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_make_out, wr_make_in, wr_lat_lo, wr_lat_hi})); // R9

  AST_LAT_READ_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsel == RSEL_LAT_LO || rsel == RSEL_LAT_HI) |-> (bus_rdata[31:16] == '0)); // R6

  AST_DIR_READ_MATCHES_OE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsel == RSEL_DIR) |-> (bus_rdata == pad_oe)); // R4

  AST_OE_STABLE_ON_LAT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lat_lo || wr_lat_hi) |=> $stable(pad_oe)); // R7

  AST_OUT_STABLE_ON_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_make_out || wr_make_in) |=> $stable(pad_out)); // R7

endmodule

// File: tb/gpio_port_masked_tb.sv
`timescale 1ns/1ps
module gpio_port_masked_tb;

  typedef struct {
    int          kind;   // 0 read data, 1 pad_out, 2 pad_oe
    logic [7:0]  addr;
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = 8'h3C;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe;

  logic        chk_req = 1'b0;
  logic        done = 1'b0;
  int          checks = 0;
  int          errors = 0;
  item_t       sb[$];

  // bench model
  logic [31:0] m_dir = '0;
  logic [31:0] m_out = '0;

  always #10 clk = ~clk;

  gpio_port_masked u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe)
  );

  task automatic model_write(input logic [7:0] a, input logic [31:0] d);
    for (int i = 0; i < 32; i++) begin
      if (a == 8'h00 && d[i]) m_dir[i] = 1'b1;
      if (a == 8'h04 && d[i]) m_dir[i] = 1'b0;
    end
    for (int k = 0; k < 16; k++) begin
      if (a == 8'h08 && d[16+k]) m_out[k]    = d[k];
      if (a == 8'h0C && d[16+k]) m_out[16+k] = d[k];
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    chk_req   = 1'b0;
    bus_addr  = a;
    bus_we    = 1'b1;
    bus_wdata = d;
    model_write(a, d);
  endtask

  task automatic expect_item(input int kind, input logic [7:0] a,
                             input logic [31:0] e, input string tag);
    item_t it;
    @(posedge clk); #2;
    bus_we   = 1'b0;
    bus_addr = (kind == 0) ? a : 8'h3C;
    it.kind = kind; it.addr = a; it.exp = e; it.tag = tag;
    sb.push_back(it);
    chk_req = 1'b1;
  endtask

  task automatic set_pads(input logic [31:0] v);
    @(posedge clk); #2;
    bus_we  = 1'b0;
    chk_req = 1'b0;
    pad_in  = v;
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (chk_req && sb.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sb.pop_front();
        act = (it.kind == 0) ? bus_rdata : (it.kind == 1) ? pad_out : pad_oe;
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s kind=%0d addr=%h actual=%h expected=%h",
                   it.tag, it.kind, it.addr, act, it.exp);
        end
      end
    end
  end

  // watchdog
  initial begin
    #(20 * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    // R1 reset state
    expect_item(2, 8'h00, 32'h0, "R1");
    expect_item(1, 8'h00, 32'h0, "R1");
    expect_item(0, 8'h04, 32'h0, "R1");
    expect_item(0, 8'h08, 32'h0, "R1");
    expect_item(0, 8'h0C, 32'h0, "R1");

    // R2 set to output
    wr(8'h00, 32'h0000_00F0);
    expect_item(2, 8'h00, m_dir, "R2");
    wr(8'h00, 32'h8000_0001);
    expect_item(2, 8'h00, 32'h8000_00F1, "R2");
    // R4 direction readback
    expect_item(0, 8'h04, m_dir, "R4");

    // R3 set to input
    wr(8'h04, 32'h0000_0030);
    expect_item(2, 8'h00, 32'h8000_00C1, "R3");
    wr(8'h04, 32'h0000_0000);
    expect_item(0, 8'h04, 32'h8000_00C1, "R3");

    // R5 masked output writes
    wr(8'h08, 32'h00FF_1234);
    expect_item(1, 8'h00, 32'h0000_0034, "R5");
    wr(8'h08, 32'h0004_FFFB);
    expect_item(1, 8'h00, 32'h0000_0030, "R5");
    wr(8'h0C, 32'hF000_ABCD);
    expect_item(1, 8'h00, 32'hA000_0030, "R5");
    wr(8'h08, 32'h0000_FFFF);
    expect_item(1, 8'h00, m_out, "R5");

    // R6 latch readback
    expect_item(0, 8'h08, 32'h0000_0030, "R6");
    expect_item(0, 8'h0C, 32'h0000_A000, "R6");

    // R7 preload while input, then enable
    wr(8'h0C, 32'h0010_0010);
    expect_item(1, 8'h00, 32'hA010_0030, "R7");
    expect_item(2, 8'h00, 32'h8000_00C1, "R7");
    wr(8'h00, 32'h0010_0000);
    expect_item(2, 8'h00, 32'h8010_00C1, "R7");
    expect_item(1, 8'h00, 32'hA010_0030, "R7");
    wr(8'h04, 32'h0010_0000);
    expect_item(0, 8'h0C, 32'h0000_A010, "R7");

    // R8 input synchronizer latency
    set_pads(32'hDEAD_BEEF);
    expect_item(0, 8'h10, 32'h0000_0000, "R8");
    expect_item(0, 8'h10, 32'hDEAD_BEEF, "R8");
    set_pads(32'h0F0F_0F0F);
    expect_item(0, 8'h10, 32'hDEAD_BEEF, "R8");
    expect_item(0, 8'h10, 32'h0F0F_0F0F, "R8");

    // R9 writes elsewhere ignored, unmapped reads zero
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h14, 32'hFFFF_FFFF);
    wr(8'h09, 32'hFFFF_FFFF);
    expect_item(2, 8'h00, m_dir, "R9");
    expect_item(1, 8'h00, m_out, "R9");
    expect_item(0, 8'h14, 32'h0, "R9");
    expect_item(0, 8'h00, 32'h0, "R9");

    @(posedge clk); #2;
    chk_req = 1'b0;
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule